// File: doc/BRIEF.md
# Debug Register Scan Access Port

This block sits behind a test access port and lets an external debug probe read and write a small bank of 32-bit registers through serial scans. The TAP controller (outside this block) supplies the current instruction and one-cycle capture, shift and update strobes. The block also supplies the serial output. On the bank side it drives an address, write data and single-cycle write and read strobes. Read data returns on a parallel input.

Each access scan carries a 40-bit frame. A write takes effect when the scan's update completes. A read is pipelined over two scans. The first scan posts the address, and the bank is read once right after that update. The result is held and shifted out in the data field of the next scan. A probe that finishes a read sequence by pointing its follow-up scan at register 0 reads a register with read side effects exactly once.

A second, 5-bit data register chooses the active scan chain. Bank access is allowed only while chain 0 is selected. The chain register comes out of reset pointing away from chain 0, so the probe must select chain 0 before any access is accepted.

Top module: `dbg_reg_access_port`

## Requirements
- R1: After reset, bank_we_o and bank_re_o are low, bank_addr_o is 0, the read holding value is 0 and the selected chain is 5'h1F. Because of this chain value, access scans have no effect until chain 0 has been selected.
- R2: The access frame is 40 bits and is shifted LSB first. Bits 31:0 are the data, bits 38:32 are the register address and bit 39 is the write flag.
- R3: When an accepted update has write flag 1, bank_we_o pulses for exactly one cycle in the cycle after the update. In that cycle bank_addr_o and bank_wdata_o carry the address and data fields of the frame.
- R4: When an accepted update has write flag 0, bank_re_o pulses for one cycle in the cycle after the update, with bank_addr_o set to the address field. The holding register loads bank_rdata_i in the cycle when bank_re_o is high and is otherwise unchanged.
- R5: On capture of an access scan, frame bits 31:0 load the holding register and bits 39:32 load zero.
- R6: A read's value comes out in the scan that follows it. A follow-up read of address 0 touches only register 0, so each side-effect read happens once per posted read.
- R7: Access scans are active only while ir_i equals 4'hC. With any other instruction, an update causes no strobe and no change to the bank.
- R8: While ir_i equals 4'h2, a 5-bit chain register is scanned LSB first. Capture loads the currently selected chain, and update makes the shifted value the selected chain.
- R9: An access update is accepted only while the selected chain is 0. Otherwise it produces no strobe.
- R10: tdo_o is bit 0 of the shift register selected by the instruction, and 0 when neither instruction is active.
- R11: bank_we_o and bank_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_i | input | 4 | Current instruction from the TAP |
| capture_dr_i | input | 1 | Capture strobe for the data register |
| shift_dr_i | input | 1 | Shift enable for the data register |
| update_dr_i | input | 1 | Update strobe for the data register |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| bank_addr_o | output | 7 | Register bank address |
| bank_wdata_o | output | 32 | Register bank write data |
| bank_we_o | output | 1 | Single-cycle write strobe |
| bank_re_o | output | 1 | Single-cycle read strobe |
| bank_rdata_i | input | 32 | Register bank read data |

## Verification
On every cycle, the assertions check the following:
- the LSB-first shift of both data registers;
- the zeroed header and the holding value loaded on capture;
- that the holding register loads bank data only right after a read strobe;
- that the two strobes are exclusive;
- that no strobe appears unless the access instruction and chain 0 were both active at the update.

Only the bench scenarios can show the two-scan read pipeline returning each value one scan late. They also show that a side-effect register is read exactly once when follow-ups address register 0. The remaining bench-only behaviours are the required chain-0 selection after reset and that writes under a wrong instruction or chain leave the bank intact.

// File: rtl/dbg_rap_pkg.sv
package dbg_rap_pkg;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 7;
  parameter int CHAIN_W = 5;
  parameter int IR_W    = 4;
  localparam int DR_W   = DATA_W + ADDR_W + 1;

  localparam logic [IR_W-1:0]    IR_ACCESS    = 4'hC;
  localparam logic [IR_W-1:0]    IR_CHAIN_SEL = 4'h2;
  localparam logic [CHAIN_W-1:0] ACCESS_CHAIN = '0;
  localparam logic [CHAIN_W-1:0] CHAIN_RST    = '1;

  // packed MSB first: wr is frame bit DR_W-1, data is the LSBs
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } acc_frame_t;
endpackage

// File: rtl/dbg_rap_ir_decode.sv
module dbg_rap_ir_decode
  import dbg_rap_pkg::*;
(
  input  logic [IR_W-1:0] ir_i,
  output logic            sel_access_o,
  output logic            sel_chain_o
);
  assign sel_access_o = (ir_i == IR_ACCESS);
  assign sel_chain_o  = (ir_i == IR_CHAIN_SEL);
endmodule

// File: rtl/dbg_rap_chain_dr.sv
module dbg_rap_chain_dr
  import dbg_rap_pkg::*;
#(
  parameter int                 W       = CHAIN_W,
  parameter logic [CHAIN_W-1:0] RST_VAL = CHAIN_RST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         tdi_i,
  output logic         tdo_o,
  output logic [W-1:0] chain_o
);
  logic [W-1:0] sr_q, chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      chain_q <= W'(RST_VAL);
    end else if (sel_i) begin
      if (capture_i)     sr_q <= chain_q;
      else if (shift_i)  sr_q <= {tdi_i, sr_q[W-1:1]};
      if (update_i)      chain_q <= sr_q;
    end
  end

  assign tdo_o   = sr_q[0];
  assign chain_o = chain_q;

  p_chain_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && update_i) |=> $stable(chain_o));
  p_chain_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && capture_i) |=> sr_q == $past(chain_o));
endmodule

// File: rtl/dbg_rap_access_dr.sv
module dbg_rap_access_dr
  import dbg_rap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              chain_ok_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              tdo_o,
  output logic              post_o,
  output acc_frame_t        frame_o
);
  logic [DR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_q <= '0;
    else if (sel_i && capture_i) sr_q <= {{(DR_W-DATA_W){1'b0}}, hold_i};
    else if (sel_i && shift_i)   sr_q <= {tdi_i, sr_q[DR_W-1:1]};
  end

  assign tdo_o   = sr_q[0];
  assign frame_o = acc_frame_t'(sr_q);
  assign post_o  = sel_i && update_i && chain_ok_i;

  p_shift_lsb_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && shift_i && !capture_i) |=>
      (sr_q[DR_W-2:0] == $past(sr_q[DR_W-1:1])) && (sr_q[DR_W-1] == $past(tdi_i)));
  p_capture_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && capture_i) |=>
      (frame_o.wr == 1'b0) && (frame_o.addr == '0) && (frame_o.data == $past(hold_i)));
endmodule

// File: rtl/dbg_rap_bank_if.sv
module dbg_rap_bank_if
  import dbg_rap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              post_i,
  input  acc_frame_t        frame_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic [DATA_W-1:0] hold_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, hold_q;
  logic              we_q, re_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      hold_q  <= '0;
    end else begin
      we_q <= post_i && frame_i.wr;
      re_q <= post_i && !frame_i.wr;
      if (post_i) addr_q <= frame_i.addr;
      if (post_i && frame_i.wr) wdata_q <= frame_i.data;
      // read result latched straight after the strobe, ready for next capture
      if (re_q) hold_q <= rdata_i;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign re_o    = re_q;
  assign hold_o  = hold_q;

  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && re_o));
  p_hold_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> hold_o == $past(rdata_i));
  p_hold_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_o |=> $stable(hold_o));
  p_write_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && frame_i.wr) |=> we_o && (addr_o == $past(frame_i.addr)) && (wdata_o == $past(frame_i.data)));
endmodule

// File: rtl/dbg_reg_access_port.sv
module dbg_reg_access_port
  import dbg_rap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [ADDR_W-1:0] bank_addr_o,
  output logic [DATA_W-1:0] bank_wdata_o,
  output logic              bank_we_o,
  output logic              bank_re_o,
  input  logic [DATA_W-1:0] bank_rdata_i
);
  logic               sel_access, sel_chain;
  logic               chain_tdo, acc_tdo, post;
  logic [CHAIN_W-1:0] chain;
  logic [DATA_W-1:0]  hold;
  acc_frame_t         frame;

  dbg_rap_ir_decode u_dec (
    .ir_i         (ir_i),
    .sel_access_o (sel_access),
    .sel_chain_o  (sel_chain)
  );

  dbg_rap_chain_dr #(.W(CHAIN_W), .RST_VAL(CHAIN_RST)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_chain),
    .capture_i (capture_dr_i),
    .shift_i   (shift_dr_i),
    .update_i  (update_dr_i),
    .tdi_i     (tdi_i),
    .tdo_o     (chain_tdo),
    .chain_o   (chain)
  );

  dbg_rap_access_dr u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_access),
    .chain_ok_i (chain == ACCESS_CHAIN),
    .capture_i  (capture_dr_i),
    .shift_i    (shift_dr_i),
    .update_i   (update_dr_i),
    .tdi_i      (tdi_i),
    .hold_i     (hold),
    .tdo_o      (acc_tdo),
    .post_o     (post),
    .frame_o    (frame)
  );

  dbg_rap_bank_if u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .post_i  (post),
    .frame_i (frame),
    .rdata_i (bank_rdata_i),
    .addr_o  (bank_addr_o),
    .wdata_o (bank_wdata_o),
    .we_o    (bank_we_o),
    .re_o    (bank_re_o),
    .hold_o  (hold)
  );

  always_comb begin
    if (sel_access)     tdo_o = acc_tdo;
    else if (sel_chain) tdo_o = chain_tdo;
    else                tdo_o = 1'b0;
  end

  p_gated_access_r7_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_o || bank_re_o) |-> $past(sel_access && update_dr_i && (chain == ACCESS_CHAIN)));
endmodule

// File: tb/dbg_reg_access_port_tb_top.sv
module dbg_reg_access_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ir = 4'h0;
  logic        capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [6:0]  addr;
  logic [31:0] wdata, rdata;
  logic        we, re;

  localparam logic [31:0] ID_VAL = 32'h4B1D_0001;
  localparam logic [6:0]  SIDE_ADDR = 7'd5;

  int total = 0, fails = 0, cyc = 0;
  int we_cnt = 0, re_cnt = 0, both_cnt = 0;
  logic [31:0] side_cnt = 0;
  logic [31:0] mem [0:127];

  logic [39:0] exp_q [$];
  string       tag_q [$];
  logic [39:0] got_q [$];

  always #10 clk = ~clk;

  dbg_reg_access_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir),
    .capture_dr_i(capture), .shift_dr_i(shift), .update_dr_i(update),
    .tdi_i(tdi), .tdo_o(tdo),
    .bank_addr_o(addr), .bank_wdata_o(wdata),
    .bank_we_o(we), .bank_re_o(re), .bank_rdata_i(rdata)
  );

  // bank model: register 5 is a counter bumped by every read
  always_comb rdata = (addr == SIDE_ADDR) ? side_cnt : mem[addr];

  always @(posedge clk) begin
    if (we) begin mem[addr] <= wdata; we_cnt <= we_cnt + 1; end
    if (re) begin
      re_cnt <= re_cnt + 1;
      if (addr == SIDE_ADDR) side_cnt <= side_cnt + 1;
    end
    if (we && re) both_cnt <= both_cnt + 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  // monitor: compare shifted-out frames against the expected queue
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0)
        check(tag_q.pop_front(), {24'h0, got_q.pop_front()}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic dr_scan(input int n, input logic [39:0] din);
    logic [39:0] dout = '0;
    @(negedge clk); capture = 1'b1;
    @(negedge clk); capture = 1'b0; shift = 1'b1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      @(negedge clk);
    end
    shift = 1'b0; update = 1'b1;
    @(negedge clk); update = 1'b0;
    @(negedge clk);
    @(negedge clk);
    got_q.push_back(dout);
  endtask

  task automatic acc(input logic wr, input logic [6:0] a, input logic [31:0] d,
                     input logic [31:0] exp_out, input string tag);
    exp_q.push_back({8'h0, exp_out});
    tag_q.push_back(tag);
    dr_scan(40, {wr, a, d});
  endtask

  task automatic chain_sel(input logic [4:0] c, input logic [4:0] exp_prev, input string tag);
    ir = 4'h2;
    exp_q.push_back({35'h0, exp_prev});
    tag_q.push_back(tag);
    dr_scan(5, {35'h0, c});
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    mem[0] = ID_VAL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    check("R1 we", {63'h0, we}, 64'h0);
    check("R1 re", {63'h0, re}, 64'h0);
    check("R1 addr", {57'h0, addr}, 64'h0);
    check("R10 tdo idle", {63'h0, tdo}, 64'h0);

    // R1 / R9: access before chain 0 is selected is ignored; R5 holding is 0
    ir = 4'hC;
    acc(1'b1, 7'd3, 32'hDEAD_BEEF, 32'h0, "R5 reset hold");
    check("R9 no write before chain 0", we_cnt, 0);
    check("R9 mem untouched", {32'h0, mem[3]}, 64'h0);

    // R8: chain capture returns reset chain 1F
    chain_sel(5'd0, 5'h1F, "R8 chain capture reset");

    // R2 / R3 write
    ir = 4'hC;
    acc(1'b1, 7'd3, 32'hA5A5_1234, 32'h0, "R3 write scan out");
    check("R3 single we", we_cnt, 1);
    check("R2 write data at addr 3", {32'h0, mem[3]}, {32'h0, 32'hA5A5_1234});
    check("R3 no re on write", re_cnt, 0);

    // R4 / R6 pipelined read
    acc(1'b0, 7'd3, 32'h0, 32'h0, "R6 post read 3");
    acc(1'b0, 7'd0, 32'h0, 32'hA5A5_1234, "R6 read 3 value");

    // R6 side-effect register read once
    acc(1'b0, SIDE_ADDR, 32'h0, ID_VAL, "R6 post side read");
    acc(1'b0, 7'd0, 32'h0, 32'h0, "R6 side value 0");
    check("R6 side read once", side_cnt, 1);
    acc(1'b0, SIDE_ADDR, 32'h0, ID_VAL, "R6 post side read 2");
    acc(1'b0, 7'd0, 32'h0, 32'h1, "R6 side value 1");
    check("R6 side read twice", side_cnt, 2);

    // R6 back-to-back reads
    acc(1'b1, 7'd7, 32'h0BAD_F00D, ID_VAL, "R3 write 7");
    acc(1'b0, 7'd7, 32'h0, ID_VAL, "R6 post read 7");
    acc(1'b0, 7'd3, 32'h0, 32'h0BAD_F00D, "R6 read 7 value");
    acc(1'b0, 7'd0, 32'h0, 32'hA5A5_1234, "R6 read 3 value again");

    // R7 / R10: wrong instruction
    ir = 4'h4;
    acc(1'b1, 7'd3, 32'hFFFF_FFFF, 32'h0, "R10 tdo zero under other ir");
    check("R7 no write under other ir", we_cnt, 2);
    ir = 4'hC;
    acc(1'b0, 7'd3, 32'h0, ID_VAL, "R7 post read");
    acc(1'b0, 7'd0, 32'h0, 32'hA5A5_1234, "R7 reg 3 unchanged");

    // R9: non-zero chain blocks access
    chain_sel(5'd1, 5'd0, "R8 chain capture 0");
    ir = 4'hC;
    acc(1'b1, 7'd3, 32'h1, ID_VAL, "R9 capture under chain 1");
    acc(1'b0, SIDE_ADDR, 32'h0, ID_VAL, "R9 read under chain 1");
    check("R9 no write on chain 1", we_cnt, 2);
    check("R9 no side read on chain 1", side_cnt, 2);
    chain_sel(5'd0, 5'd1, "R8 chain capture 1");
    ir = 4'hC;
    acc(1'b0, 7'd3, 32'h0, ID_VAL, "R9 post read");
    acc(1'b0, 7'd0, 32'h0, 32'hA5A5_1234, "R9 reg 3 unchanged");

    repeat (4) @(negedge clk);
    check("R11 strobes exclusive", both_cnt, 0);
    check("scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule